// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the command sequencer of a serial flash device for the mode that programs two bytes per command while stepping the address automatically. A byte stream from the serial deserializer reaches it framed by an active-low chip select. The first programming command of a session carries an opcode, a 24-bit start address and two data bytes. Each later command carries only the opcode and two data bytes, and the block supplies the next even address itself.

While the session is open, the block holds a status flag and accepts only a further programming command or the write-disable command. Each data pair goes into a byte memory after a fixed programming delay. A busy indication can be placed on the serial output line while the chip select is low.

The storage array is modelled as a byte memory with an asynchronous read port, so the programmed contents can be observed. Its address width is `MEM_AW`: only the low `MEM_AW` bits of the 24-bit address are used, and the upper bits are ignored. The programming delay is `PROG_CYCLES` clock cycles.

Top module: `aai_seq`

## Requirements
- R1: After reset, `aai_flag`, `wel`, `busy` and `so_oe` are 0 and every memory byte reads 8'hFF.
- R2: A frame of exactly one byte 8'h06, received outside a session, sets `wel`. A session-opening frame is exactly six bytes: opcode 8'hAD, address bytes from most to least significant, then data byte 0 and data byte 1. It is ignored unless `wel` is 1, address bit 0 is 0 and `busy` is 0.
- R3: An accepted opening frame sets `aai_flag` and raises `busy` for `PROG_CYCLES` cycles. When `busy` falls, data byte 0 is stored at the even address and data byte 1 at the next odd address.
- R4: Inside a session, a three-byte frame (8'hAD, data 0, data 1) programs the pair at the previous pair's address plus 2.
- R5: A programming frame that completes while `busy` is 1 is ignored and does not advance the address.
- R6: Inside a session, single-byte frames 8'h06, 8'h70 and 8'h80 have no effect.
- R7: A single-byte frame 8'h04 clears both `aai_flag` and `wel`.
- R8: `aai_flag` is never 1 while `wel` is 0.
- R9: A single-byte frame 8'h70 outside a session enables busy-on-output. While that option is on, a session is open and `cs_n` is 0, `so_oe` is 1 and `so_out` is 0 during programming and 1 when ready. Otherwise `so_oe` is 0.
- R10: A single-byte frame 8'h80 outside a session turns busy-on-output off.
- R11: When the pair ending at the top memory address (all ones) finishes programming, the session ends and `aai_flag` and `wel` both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; its rising edge closes a frame |
| byte_vld | input | 1 | One received byte is present on `byte_in` this cycle |
| byte_in | input | 8 | Received command, address or data byte |
| rd_addr | input | MEM_AW | Memory read address |
| rd_data | output | 8 | Memory byte at `rd_addr` |
| aai_flag | output | 1 | Word-program session open |
| wel | output | 1 | Write enable latch |
| busy | output | 1 | Programming delay running |
| so_oe | output | 1 | Serial output driven with the ready/busy state |
| so_out | output | 1 | Ready/busy value: 0 busy, 1 ready |

## Verification
On every cycle, the assertions check that a session is never open without the write latch, that the session pointer stays even, that the timer is never restarted while it runs, and that a write-disable leaves both flags clear. Only the bench's scenarios can show which bytes land at which addresses. They also cover the frames that are dropped without leaving a trace (no latch, odd address, busy timer, disallowed opcodes), the busy-on-output value seen with the chip select low, and the automatic close at the top address.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_WRDI    = 8'h04;
  localparam logic [7:0] OP_WORD    = 8'hAD;
  localparam logic [7:0] OP_SO_ON   = 8'h70;
  localparam logic [7:0] OP_SO_OFF  = 8'h80;
  localparam int         OPEN_LEN   = 6;
  localparam int         NEXT_LEN   = 3;

  // True when the pair containing address a ends at the top of a 2**aw space
  function automatic logic pair_is_last(input logic [23:0] a, input int aw);
    logic [23:0] top;
    top = (24'd1 << aw) - 24'd1;
    return ((a & top) | 24'd1) == top;
  endfunction

  // Even address that follows the pair at a
  function automatic logic [23:0] pair_next(input logic [23:0] a);
    return {a[23:1], 1'b0} + 24'd2;
  endfunction
endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx #(
  parameter int MAX_BYTES = 6,
  localparam int CW = $clog2(MAX_BYTES + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   byte_vld,
  input  logic [7:0]             byte_in,
  output logic                   frame_done,
  output logic [CW-1:0]          frame_len,
  output logic [MAX_BYTES*8-1:0] frame_buf
);
  localparam logic [CW-1:0] SAT = CW'(MAX_BYTES + 1);
  logic cs_q;

  assign frame_done = cs_n & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      frame_len <= '0;
      frame_buf <= '0;
    end else begin
      cs_q <= cs_n;
      if (frame_done) begin
        frame_len <= '0;
      end else if (!cs_n && byte_vld) begin
        if (frame_len < CW'(MAX_BYTES))
          frame_buf[frame_len*8 +: 8] <= byte_in;
        if (frame_len != SAT)
          frame_len <= frame_len + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer #(
  parameter int CYCLES = 12,
  localparam int TW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fin
);
  logic [TW-1:0] cnt;

  assign busy = (cnt != '0);
  assign fin  = (cnt == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= TW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt == '0));
  a_r3_fin_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
endmodule

// File: rtl/aai_byte_mem.sv
module aai_byte_mem #(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wd_even,
  input  logic [7:0]    wd_odd,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr) begin
      mem[{waddr[AW-1:1], 1'b0}] <= wd_even;
      mem[{waddr[AW-1:1], 1'b1}] <= wd_odd;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/aai_seq.sv
module aai_seq
  import aai_seq_pkg::*;
#(
  parameter int MEM_AW      = 6,
  parameter int PROG_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              aai_flag,
  output logic              wel,
  output logic              busy,
  output logic              so_oe,
  output logic              so_out
);
  localparam int CW = $clog2(OPEN_LEN + 2);

  logic                  frame_done;
  logic [CW-1:0]         frame_len;
  logic [OPEN_LEN*8-1:0] fbuf;
  logic                  prog_fin;

  aai_frame_rx #(.MAX_BYTES(OPEN_LEN)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
    .byte_in(byte_in), .frame_done(frame_done), .frame_len(frame_len),
    .frame_buf(fbuf)
  );

  // Byte fields of the closed frame
  logic [7:0]  op;
  logic [23:0] open_addr;
  assign op        = fbuf[7:0];
  assign open_addr = {fbuf[15:8], fbuf[23:16], fbuf[31:24]};

  logic wel_q, aai_q, so_en_q;
  logic [MEM_AW-1:0] ptr_q;

  // Named command events
  logic single, ev_wren, ev_wrdi, ev_so_on, ev_so_off;
  logic open_ok, next_ok, prog_start, auto_end;
  assign single    = frame_done && (frame_len == CW'(1));
  assign ev_wren   = single && (op == OP_WREN)   && !aai_q;
  assign ev_wrdi   = single && (op == OP_WRDI);
  assign ev_so_on  = single && (op == OP_SO_ON)  && !aai_q;
  assign ev_so_off = single && (op == OP_SO_OFF) && !aai_q;
  assign open_ok   = frame_done && !aai_q && (op == OP_WORD) &&
                     (frame_len == CW'(OPEN_LEN)) && wel_q &&
                     !open_addr[0] && !busy;
  assign next_ok   = frame_done && aai_q && (op == OP_WORD) &&
                     (frame_len == CW'(NEXT_LEN)) && !busy;
  assign prog_start = open_ok || next_ok;

  logic [MEM_AW-1:0] start_addr;
  logic [7:0]        start_d0, start_d1;
  assign start_addr = open_ok ? open_addr[MEM_AW-1:0] : ptr_q;
  assign start_d0   = open_ok ? fbuf[39:32] : fbuf[15:8];
  assign start_d1   = open_ok ? fbuf[47:40] : fbuf[23:16];

  logic [MEM_AW-1:0] pend_addr;
  logic [7:0]        pend_d0, pend_d1;
  logic              pend_last;

  aai_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .fin(prog_fin)
  );

  assign auto_end = prog_fin && pend_last && aai_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q     <= 1'b0;
      aai_q     <= 1'b0;
      so_en_q   <= 1'b0;
      ptr_q     <= '0;
      pend_addr <= '0;
      pend_d0   <= 8'hFF;
      pend_d1   <= 8'hFF;
      pend_last <= 1'b0;
    end else begin
      if (ev_wrdi || auto_end) wel_q <= 1'b0;
      else if (ev_wren)        wel_q <= 1'b1;

      if (ev_wrdi || auto_end) aai_q <= 1'b0;
      else if (open_ok)        aai_q <= 1'b1;

      if (ev_so_on)       so_en_q <= 1'b1;
      else if (ev_so_off) so_en_q <= 1'b0;

      if (prog_start) begin
        ptr_q     <= MEM_AW'(pair_next(24'(start_addr)));
        pend_addr <= start_addr;
        pend_d0   <= start_d0;
        pend_d1   <= start_d1;
        pend_last <= pair_is_last(24'(start_addr), MEM_AW);
      end
    end
  end

  aai_byte_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr(prog_fin), .waddr(pend_addr),
    .wd_even(pend_d0), .wd_odd(pend_d1), .raddr(rd_addr), .rdata(rd_data)
  );

  assign aai_flag = aai_q;
  assign wel      = wel_q;
  assign so_oe    = so_en_q && aai_q && !cs_n;
  assign so_out   = !busy;

  a_r8_session_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    aai_q |-> wel_q);
  a_r2_open_after_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_q) |-> $past(wel_q));
  a_r4_ptr_even: assert property (@(posedge clk) disable iff (!rst_n)
    aai_q |-> !ptr_q[0]);
  a_r7_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrdi |=> (!aai_q && !wel_q));
  a_r11_auto_close: assert property (@(posedge clk) disable iff (!rst_n)
    auto_end |=> (!aai_q && !busy));
endmodule

// File: tb/aai_seq_tb.sv
`timescale 1ns/1ps
module aai_seq_tb;
  localparam int AW = 6;
  localparam int PC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic aai_flag, wel, busy, so_oe, so_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  aai_seq #(.MEM_AW(AW), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_vld(byte_vld),
    .byte_in(byte_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .aai_flag(aai_flag), .wel(wel), .busy(busy), .so_oe(so_oe), .so_out(so_out)
  );

  // Continuation data pairs, programmed from address 8'h12 upward
  localparam logic [15:0] PAIRS [4] = '{16'hA2A3, 16'h5A5B, 16'h0001, 16'hFE7C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5,
                      input int n);
    logic [7:0] bs [6];
    bs = '{b0, b1, b2, b3, b4, b5};
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_n = 1'b0; byte_vld = 1'b1; byte_in = bs[i];
    end
    @(negedge clk);
    byte_vld = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    send(op, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_mem(input string req, input int a, input logic [7:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic chk_so(input string req, input logic exp_oe, input logic exp_v);
    @(negedge clk);
    cs_n = 1'b0;
    #1;
    chk(req, so_oe, exp_oe);
    if (exp_oe) chk(req, so_out, exp_v);
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 aai", aai_flag, 0);
    chk("R1 wel", wel, 0);
    chk("R1 busy", busy, 0);
    chk("R1 so_oe", so_oe, 0);
    chk_mem("R1 mem", 0, 8'hFF);
    chk_mem("R1 mem top", 63, 8'hFF);

    // R2 opening without write latch is ignored
    send(8'hAD, 8'h00, 8'h00, 8'h10, 8'h11, 8'h22, 6);
    chk("R2 no wel aai", aai_flag, 0);
    chk("R2 no wel busy", busy, 0);
    chk_mem("R2 no wel mem", 16, 8'hFF);

    cmd1(8'h06);
    chk("R2 wren", wel, 1);
    cmd1(8'h70);  // R9 enable busy-on-output
    // R2 odd start address ignored
    send(8'hAD, 8'h00, 8'h00, 8'h11, 8'h33, 8'h44, 6);
    chk("R2 odd aai", aai_flag, 0);
    chk("R2 odd busy", busy, 0);
    chk("R2 odd wel", wel, 1);

    // R3 opening frame
    send(8'hAD, 8'h00, 8'h00, 8'h10, 8'hA0, 8'hA1, 6);
    chk("R3 aai", aai_flag, 1);
    chk("R3 busy", busy, 1);
    chk_mem("R3 not yet", 16, 8'hFF);
    chk_so("R9 busy on so", 1'b1, 1'b0);
    wait_idle();
    chk_so("R9 ready on so", 1'b1, 1'b1);
    chk_mem("R3 even", 16, 8'hA0);
    chk_mem("R3 odd", 17, 8'hA1);

    // R4 table of continuation pairs
    for (int i = 0; i < 4; i++) begin
      send(8'hAD, PAIRS[i][15:8], PAIRS[i][7:0], 0, 0, 0, 3);
      wait_idle();
      chk_mem("R4 even", 18 + 2*i, PAIRS[i][15:8]);
      chk_mem("R4 odd", 19 + 2*i, PAIRS[i][7:0]);
    end

    // R5 frame during busy ignored
    send(8'hAD, 8'hC1, 8'hC2, 0, 0, 0, 3);
    send(8'hAD, 8'hD1, 8'hD2, 0, 0, 0, 3);
    wait_idle();
    send(8'hAD, 8'hE1, 8'hE2, 0, 0, 0, 3);
    wait_idle();
    chk_mem("R5 accepted", 26, 8'hC1);
    chk_mem("R5 no skip even", 28, 8'hE1);
    chk_mem("R5 no skip odd", 29, 8'hE2);
    chk_mem("R5 nothing beyond", 30, 8'hFF);

    // R6 other opcodes ignored in session
    cmd1(8'h80);
    cmd1(8'h06);
    chk("R6 aai kept", aai_flag, 1);
    chk_so("R6 so still on", 1'b1, 1'b1);

    // R7 write disable
    cmd1(8'h04);
    chk("R7 aai", aai_flag, 0);
    chk("R7 wel", wel, 0);
    chk_so("R9 off outside session", 1'b0, 1'b0);

    // R10 disable busy-on-output, then new session at top
    cmd1(8'h80);
    cmd1(8'h06);
    send(8'hAD, 8'h00, 8'h00, 8'h3C, 8'h55, 8'h66, 6);
    chk("R10 session open", aai_flag, 1);
    chk_so("R10 so off", 1'b0, 1'b0);
    wait_idle();
    send(8'hAD, 8'h77, 8'h88, 0, 0, 0, 3);
    chk("R11 open while busy", aai_flag, 1);
    wait_idle();
    chk("R11 aai", aai_flag, 0);
    chk("R11 wel", wel, 0);
    chk_mem("R11 top-1", 62, 8'h77);
    chk_mem("R11 top", 63, 8'h88);
    chk_mem("R11 prev", 60, 8'h55);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule